// File: doc/BRIEF.md
# Two-Port Hardware Token Bank

This block arbitrates ownership of a small set of shared tokens between two independent synchronous ports, called left and right. Each token stands for a shared resource. Software on one side claims a token before it touches the resource and hands the token back when done. The hardware guarantees that the two sides never hold the same token at once. The bank has no storage array of its own. A dedicated bank select on each port takes the place of the memory select, the low address bits pick a token, and a single write bit carries the command.

A write of 0 asks for the token and a write of 1 gives it back. A request that meets a token held by the opposite side is not lost. It is kept as a pending claim and turns into ownership on the same clock edge at which the holder lets go. When both sides ask for a free token in the same cycle, the left side gets it. A read reports ownership from the reader's point of view: an all-zero word means "you hold it" and an all-ones word means "you do not".

Top module: `dual_port_token_bank`

## Requirements
- R1: After reset no token is owned: every read from either port returns all ones, and both read buses rest at all ones.
- R2: A write of 0 (`wbit`) to a free token grants it to the writing port. A read presented in cycle T returns, in cycle T+1, all zeros if the reading port holds the token and all ones otherwise.
- R3: A write of 1 from the port that holds a token frees it.
- R4: A write of 1 from a port that does not hold the token changes nothing: the holder keeps the token and any pending claim stays in place.
- R5: No token is ever held by both ports at the same time.
- R6: When both ports write 0 to the same free token in the same cycle, the left port is granted and the right port's claim becomes pending.
- R7: A write of 0 to a token held by the other side is remembered. It is granted on the clock edge that registers the holder's release, so a read in the following cycle already returns all zeros.
- R8: With `sel` low a port's writes are ignored. A read needs `sel` and `oe` high and `we` low. Without a read, that port's read bus shows all ones.
- R9: The tokens are independent. The token is chosen by the binary value of `addr`, token 0 at address 0, and the two ports may hold different tokens at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_l | input | 1 | Left bank select |
| oe_l | input | 1 | Left output enable (read) |
| we_l | input | 1 | Left write enable |
| addr_l | input | ADDR_W (3) | Left token index |
| wbit_l | input | 1 | Left command: 0 claim, 1 release |
| rdata_l | output | DATA_W (16) | Left read word, registered |
| sel_r | input | 1 | Right bank select |
| oe_r | input | 1 | Right output enable (read) |
| we_r | input | 1 | Right write enable |
| addr_r | input | ADDR_W (3) | Right token index |
| wbit_r | input | 1 | Right command: 0 claim, 1 release |
| rdata_r | output | DATA_W (16) | Right read word, registered |

## Verification
A corrupted owner field shows at the ports one cycle after either side reads the token. The word comes back as zeros where ones are expected, or as zeros on both sides. A lost or stale pending claim cannot be seen until the holder releases. It then shows on the next read as a waiting side that never turns to zeros, or as a side that wins a token it never asked for. The directed scenarios therefore read both sides right after every ownership change, including the cycle just after a hand-over.

// File: rtl/token_bank_pkg.sv
`timescale 1ns/1ps
package token_bank_pkg;

    typedef enum logic [1:0] {
        HOLDER_NONE  = 2'd0,
        HOLDER_LEFT  = 2'd1,
        HOLDER_RIGHT = 2'd2
    } holder_e;

    typedef struct packed {
        holder_e holder;
        logic    wait_l;
        logic    wait_r;
    } token_state_t;

    localparam token_state_t TOKEN_RESET = '{holder: HOLDER_NONE, wait_l: 1'b0, wait_r: 1'b0};

endpackage

// File: rtl/tbk_port_decode.sv
`timescale 1ns/1ps
module tbk_port_decode #(
    parameter int N_TOKENS = 8,
    parameter int ADDR_W   = $clog2(N_TOKENS)
) (
    input  logic                sel,
    input  logic                oe,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wbit,
    output logic [N_TOKENS-1:0] claim_vec,
    output logic [N_TOKENS-1:0] drop_vec,
    output logic                rd_en,
    output logic [ADDR_W-1:0]   rd_idx
);

    logic wr_cmd;

    always_comb begin
        wr_cmd = sel & we;
        rd_en  = sel & oe & ~we;
        rd_idx = addr;
    end

    for (genvar i = 0; i < N_TOKENS; i++) begin : g_dec
        always_comb begin
            claim_vec[i] = wr_cmd && (addr == ADDR_W'(i)) && !wbit;
            drop_vec[i]  = wr_cmd && (addr == ADDR_W'(i)) &&  wbit;
        end
    end

endmodule

// File: rtl/tbk_token_cell.sv
`timescale 1ns/1ps
module tbk_token_cell
    import token_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic claim_l,
    input  logic drop_l,
    input  logic claim_r,
    input  logic drop_r,
    output logic held_l,
    output logic held_r
);

    token_state_t st_q, st_d;
    holder_e      after_drop;
    logic         want_l, want_r;

    always_comb begin
        st_d       = st_q;
        after_drop = st_q.holder;
        // a release counts only for the current holder
        if (st_q.holder == HOLDER_LEFT && drop_l)  after_drop = HOLDER_NONE;
        if (st_q.holder == HOLDER_RIGHT && drop_r) after_drop = HOLDER_NONE;

        want_l = st_q.wait_l | claim_l;
        want_r = st_q.wait_r | claim_r;

        st_d.holder = after_drop;
        if (after_drop == HOLDER_NONE) begin
            if (want_l)      st_d.holder = HOLDER_LEFT;
            else if (want_r) st_d.holder = HOLDER_RIGHT;
        end
        st_d.wait_l = want_l && (st_d.holder != HOLDER_LEFT);
        st_d.wait_r = want_r && (st_d.holder != HOLDER_RIGHT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TOKEN_RESET;
        else        st_q <= st_d;
    end

    always_comb begin
        held_l = (st_q.holder == HOLDER_LEFT);
        held_r = (st_q.holder == HOLDER_RIGHT);
    end

endmodule

// File: rtl/tbk_read_port.sv
`timescale 1ns/1ps
module tbk_read_port #(
    parameter int N_TOKENS = 8,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = $clog2(N_TOKENS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_idx,
    input  logic [N_TOKENS-1:0] held_vec,
    output logic [DATA_W-1:0]   rdata
);

    logic [DATA_W-1:0] word_q, word_d;

    always_comb begin
        word_d = '1;
        if (rd_en && held_vec[rd_idx]) word_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '1;
        else        word_q <= word_d;
    end

    assign rdata = word_q;

endmodule

// File: rtl/dual_port_token_bank.sv
`timescale 1ns/1ps
module dual_port_token_bank #(
    parameter int N_TOKENS = 8,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = $clog2(N_TOKENS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_l,
    input  logic              oe_l,
    input  logic              we_l,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic              wbit_l,
    output logic [DATA_W-1:0] rdata_l,
    input  logic              sel_r,
    input  logic              oe_r,
    input  logic              we_r,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic              wbit_r,
    output logic [DATA_W-1:0] rdata_r
);

    logic [N_TOKENS-1:0] claim_l, drop_l, claim_r, drop_r;
    logic [N_TOKENS-1:0] held_l, held_r;
    logic                rd_en_l, rd_en_r;
    logic [ADDR_W-1:0]   rd_idx_l, rd_idx_r;

    tbk_port_decode #(.N_TOKENS(N_TOKENS), .ADDR_W(ADDR_W)) i_dec_l (
        .sel(sel_l), .oe(oe_l), .we(we_l), .addr(addr_l), .wbit(wbit_l),
        .claim_vec(claim_l), .drop_vec(drop_l), .rd_en(rd_en_l), .rd_idx(rd_idx_l)
    );

    tbk_port_decode #(.N_TOKENS(N_TOKENS), .ADDR_W(ADDR_W)) i_dec_r (
        .sel(sel_r), .oe(oe_r), .we(we_r), .addr(addr_r), .wbit(wbit_r),
        .claim_vec(claim_r), .drop_vec(drop_r), .rd_en(rd_en_r), .rd_idx(rd_idx_r)
    );

    for (genvar i = 0; i < N_TOKENS; i++) begin : g_tok
        tbk_token_cell i_cell (
            .clk(clk), .rst_n(rst_n),
            .claim_l(claim_l[i]), .drop_l(drop_l[i]),
            .claim_r(claim_r[i]), .drop_r(drop_r[i]),
            .held_l(held_l[i]), .held_r(held_r[i])
        );
    end

    tbk_read_port #(.N_TOKENS(N_TOKENS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_rd_l (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en_l), .rd_idx(rd_idx_l),
        .held_vec(held_l), .rdata(rdata_l)
    );

    tbk_read_port #(.N_TOKENS(N_TOKENS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_rd_r (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en_r), .rd_idx(rd_idx_r),
        .held_vec(held_r), .rdata(rdata_r)
    );

endmodule

// File: rtl/tbk_checker.sv
`timescale 1ns/1ps
module tbk_checker #(
    parameter int N_TOKENS = 8,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = $clog2(N_TOKENS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sel_l,
    input logic                oe_l,
    input logic                we_l,
    input logic [ADDR_W-1:0]   addr_l,
    input logic                wbit_l,
    input logic [DATA_W-1:0]   rdata_l,
    input logic                sel_r,
    input logic                we_r,
    input logic [ADDR_W-1:0]   addr_r,
    input logic                wbit_r,
    input logic [N_TOKENS-1:0] held_l,
    input logic [N_TOKENS-1:0] held_r
);

    // R5
    a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (held_l & held_r) == '0);

    // R1
    a_r1_reset_free: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (held_l == '0 && held_r == '0));

    // R2
    a_r2_read_word: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_l == '0) || (rdata_l == '1));

    // R2
    a_r2_grant_free: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_l && we_l && !wbit_l && !held_l[addr_l] && !held_r[addr_l])
        |=> held_l[$past(addr_l)]);

    // R3
    a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_l && we_l && wbit_l && held_l[addr_l]) |=> !held_l[$past(addr_l)]);

    // R6
    a_r6_left_first: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_l && we_l && !wbit_l && sel_r && we_r && !wbit_r && addr_l == addr_r
         && !held_l[addr_l] && !held_r[addr_l]) |=> held_l[$past(addr_l)]);

    // R8
    a_r8_quiet_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!(sel_l && we_l) && !(sel_r && we_r)) |=> ($stable(held_l) && $stable(held_r)));

    // R8
    a_r8_idle_ones: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_l && oe_l && !we_l) |=> (rdata_l == '1));

endmodule

bind dual_port_token_bank tbk_checker #(
    .N_TOKENS(N_TOKENS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) i_tbk_checker (
    .clk(clk), .rst_n(rst_n),
    .sel_l(sel_l), .oe_l(oe_l), .we_l(we_l), .addr_l(addr_l), .wbit_l(wbit_l),
    .rdata_l(rdata_l),
    .sel_r(sel_r), .we_r(we_r), .addr_r(addr_r), .wbit_r(wbit_r),
    .held_l(held_l), .held_r(held_r)
);

// File: tb/test_dual_port_token_bank.sv
`timescale 1ns/1ps
module test_dual_port_token_bank;

    localparam int N  = 8;
    localparam int W  = 16;
    localparam int AW = 3;
    localparam logic [W-1:0] MINE  = '0;
    localparam logic [W-1:0] OTHER = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_l = 0, oe_l = 0, we_l = 0, wbit_l = 0;
    logic sel_r = 0, oe_r = 0, we_r = 0, wbit_r = 0;
    logic [AW-1:0] addr_l = '0, addr_r = '0;
    logic [W-1:0]  rdata_l, rdata_r;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dual_port_token_bank #(.N_TOKENS(N), .DATA_W(W)) i_dual_port_token_bank (
        .clk(clk), .rst_n(rst_n),
        .sel_l(sel_l), .oe_l(oe_l), .we_l(we_l), .addr_l(addr_l), .wbit_l(wbit_l), .rdata_l(rdata_l),
        .sel_r(sel_r), .oe_r(oe_r), .we_r(we_r), .addr_r(addr_r), .wbit_r(wbit_r), .rdata_r(rdata_r)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input int p, input logic s, input logic o, input logic w,
                         input int idx, input logic b);
        if (p == 0) begin
            sel_l = s; oe_l = o; we_l = w; addr_l = AW'(idx); wbit_l = b;
        end else begin
            sel_r = s; oe_r = o; we_r = w; addr_r = AW'(idx); wbit_r = b;
        end
    endtask

    task automatic quiet();
        drive(0, 0, 0, 0, 0, 0);
        drive(1, 0, 0, 0, 0, 0);
    endtask

    // one write cycle; use_sel=0 drops the bank select
    task automatic wr(input int p, input int idx, input logic b, input logic use_sel = 1'b1);
        @(negedge clk);
        drive(p, use_sel, 0, 1, idx, b);
        @(negedge clk);
        quiet();
    endtask

    task automatic wr2(input int idx, input logic bl, input logic br);
        @(negedge clk);
        drive(0, 1, 0, 1, idx, bl);
        drive(1, 1, 0, 1, idx, br);
        @(negedge clk);
        quiet();
    endtask

    // read presented for one cycle, result sampled one cycle later
    task automatic rd(input int p, input int idx, input logic use_oe, output logic [W-1:0] v);
        @(negedge clk);
        drive(p, 1, use_oe, 0, idx, 0);
        @(negedge clk);
        v = (p == 0) ? rdata_l : rdata_r;
        quiet();
    endtask

    task automatic t_reset();
        logic [W-1:0] v;
        check("R1 idle left bus", rdata_l, OTHER);
        check("R1 idle right bus", rdata_r, OTHER);
        for (int i = 0; i < N; i++) begin
            rd(0, i, 1, v);
            check("R1 left read after reset", v, OTHER);
            rd(1, i, 1, v);
            check("R1 right read after reset", v, OTHER);
        end
    endtask

    task automatic t_grant_release();
        logic [W-1:0] v;
        wr(0, 2, 0);
        rd(0, 2, 1, v); check("R2 holder reads zeros", v, MINE);
        rd(1, 2, 1, v); check("R2 other side reads ones", v, OTHER);
        wr(0, 2, 1);
        rd(0, 2, 1, v); check("R3 freed by holder", v, OTHER);
        wr(1, 2, 0);
        rd(1, 2, 1, v); check("R3 freed token grantable", v, MINE);
        wr(1, 2, 1);
    endtask

    task automatic t_foreign_release();
        logic [W-1:0] v;
        wr(1, 5, 0);
        wr(0, 5, 1);
        rd(1, 5, 1, v); check("R4 holder keeps token", v, MINE);
        rd(0, 5, 1, v); check("R4 releaser gains nothing", v, OTHER);
        wr(1, 5, 1);
        rd(1, 5, 1, v); check("R4 holder release still works", v, OTHER);
    endtask

    task automatic t_tie();
        logic [W-1:0] v;
        wr2(3, 0, 0);
        rd(0, 3, 1, v); check("R6 left wins tie", v, MINE);
        rd(1, 3, 1, v); check("R6 right loses tie", v, OTHER);
        wr(0, 3, 1);
        rd(1, 3, 1, v); check("R7 tie loser granted on release", v, MINE);
        wr(1, 3, 1);
    endtask

    task automatic t_pending();
        logic [W-1:0] v;
        wr(0, 6, 0);
        wr(1, 6, 0);
        rd(1, 6, 1, v); check("R7 waiter not yet granted", v, OTHER);
        wr(1, 6, 1);
        rd(0, 6, 1, v); check("R4 waiter release leaves holder", v, MINE);
        wr(0, 6, 1);
        rd(1, 6, 1, v); check("R7 pending granted at release", v, MINE);
        rd(0, 6, 1, v); check("R7 old holder lost token", v, OTHER);
        wr(1, 6, 1);
    endtask

    task automatic t_select();
        logic [W-1:0] v;
        wr(0, 1, 0, 1'b0);
        rd(0, 1, 1, v); check("R8 write without select ignored", v, OTHER);
        wr(0, 1, 0);
        rd(0, 1, 0, v); check("R8 read without oe shows ones", v, OTHER);
        rd(0, 1, 1, v); check("R8 read with oe shows zeros", v, MINE);
        wr(0, 1, 1, 1'b0);
        rd(0, 1, 1, v); check("R8 release without select ignored", v, MINE);
        wr(0, 1, 1);
    endtask

    task automatic t_independent();
        logic [W-1:0] v;
        wr(0, 0, 0);
        wr(1, 7, 0);
        rd(0, 0, 1, v); check("R9 left holds token 0", v, MINE);
        rd(0, 7, 1, v); check("R9 left not on token 7", v, OTHER);
        rd(1, 7, 1, v); check("R9 right holds token 7", v, MINE);
        rd(1, 0, 1, v); check("R9 right not on token 0", v, OTHER);
        rd(0, 4, 1, v); check("R9 untouched token free", v, OTHER);
        wr(0, 0, 1);
        wr(1, 7, 1);
        rd(1, 0, 1, v); check("R9 token 0 freed", v, OTHER);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_grant_release();
        t_foreign_release();
        t_tie();
        t_pending();
        t_select();
        t_independent();
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule